// File: doc/BRIEF.md
# Peripheral Reset and Enable Controller

This block is a register bank on a simple synchronous bus. It drives a reset line and an enable line for each peripheral. Two groups of 32-bit words hold the control bits. Four words form the reset group and four words form the enable group, which gives 128 lines per group.

On every write that lands in a group, the block compares the old word with the new word bit by bit:

- In the reset group, a bit that falls from 1 to 0 releases the reset of its line.
- In the enable group, a bit that rises from 0 to 1 switches its line on.

Each such event gives a one-cycle strobe on the line's event output. It also sets the line's level output to the value signalled. Every other word inside the bank stores what is written and has no side effect.

A bus master uses the block by writing words. The consumers watch the level vectors, or they react to the event strobes.

The bus FSM has two named states:

- `BUS_IDLE` drives zero read data. It moves to `BUS_RESP` when `rd_en` is high, and stays in `BUS_IDLE` otherwise.
- `BUS_RESP` presents the captured word for one cycle. It stays in `BUS_RESP` on another read and returns to `BUS_IDLE` otherwise.

Top module: `periph_gate_ctrl`

## Requirements
- R1: After reset every register reads 0, every bit of `rst_lvl` is 1, every bit of `en_lvl` is 0, and both event vectors are 0.
- R2: A read requested with `rd_en` in cycle N shows, in cycle N+1, the word at index `addr>>2` (the two low address bits are ignored). `rdata` is 0 in any cycle that does not follow a read request.
- R3: A read at a byte offset above 0x90 returns 0 and changes no state.
- R4: A write at a byte offset above 0x90 is discarded: no register changes and no event is produced.
- R5: A write to the reset group (offsets 0x10, 0x14, 0x18, 0x1C, group word k) has the following effect for each bit b that goes from 1 to 0. In the cycle after the write, `rst_evt[32*k+b]` is 1 and `rst_lvl[32*k+b]` becomes 0.
- R6: A write to the enable group (offsets 0x30, 0x34, 0x38, 0x3C, group word k) has the following effect for each bit b that goes from 0 to 1. In the cycle after the write, `en_evt[32*k+b]` is 1 and `en_lvl[32*k+b]` becomes 1.
- R7: Opposite transitions (a reset bit rising, an enable bit falling) produce no event and leave the level unchanged. The register still stores the new word.
- R8: A write to an in-range offset outside both groups stores the word unchanged and produces no event.
- R9: Every event strobe lasts exactly one cycle. The two groups never strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| rst_evt | output | 128 | One-cycle reset-release strobes |
| rst_lvl | output | 128 | Last reset value signalled per line |
| en_evt | output | 128 | One-cycle enable strobes |
| en_lvl | output | 128 | Last enable value signalled per line |

## Verification
The assertions assume that `rst_n` is low from time zero until at least the first clock edge. They also assume that `wr_en`, `rd_en` and `addr` carry known values at each rising edge.

The stimulus drives every input on the falling edge and issues one request per call, so each edge sees a stable, single operation. Reads and writes never share a cycle.

Random addresses are drawn from four buckets:
- the reset group,
- the enable group,
- other in-range words,
- offsets above the bank, including unaligned ones near 0x90.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/pgc_bank.sv
module pgc_bank #(
    parameter int IDX_W   = 6,
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] old_word,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem_q [N_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WORDS; i++) mem_q[i] <= '0;
        end else if (we && (widx < IDX_W'(N_WORDS))) begin
            mem_q[widx] <= wdata;
        end
    end

    always_comb begin
        old_word = '0;
        rd_word  = '0;
        if (widx < IDX_W'(N_WORDS)) old_word = mem_q[widx];
        if (ridx < IDX_W'(N_WORDS)) rd_word  = mem_q[ridx];
    end
endmodule

// File: rtl/pgc_edge_group.sv
module pgc_edge_group #(
    parameter int   N_REGS   = 4,
    parameter int   WORD_W   = 32,
    parameter bit   RISE     = 1'b0,
    parameter bit   LVL_INIT = 1'b1,
    localparam int  GI_W     = (N_REGS > 1) ? $clog2(N_REGS) : 1,
    localparam int  LINES    = N_REGS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [GI_W-1:0]   gidx,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_word,
    output logic [LINES-1:0]  evt,
    output logic [LINES-1:0]  lvl
);
    logic [WORD_W-1:0] edge_mask;

    generate
        if (RISE) begin : g_rise
            assign edge_mask = ~old_word & new_word;
        end else begin : g_fall
            assign edge_mask = old_word & ~new_word;
        end
    endgenerate

    for (genvar r = 0; r < N_REGS; r++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                evt[r*WORD_W +: WORD_W] <= '0;
                lvl[r*WORD_W +: WORD_W] <= {WORD_W{LVL_INIT}};
            end else if (hit && (gidx == GI_W'(r))) begin
                evt[r*WORD_W +: WORD_W] <= edge_mask;
                if (RISE) lvl[r*WORD_W +: WORD_W] <= lvl[r*WORD_W +: WORD_W] | edge_mask;
                else      lvl[r*WORD_W +: WORD_W] <= lvl[r*WORD_W +: WORD_W] & ~edge_mask;
            end else begin
                evt[r*WORD_W +: WORD_W] <= '0;
            end
        end
    end
endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl #(
    parameter int  ADDR_W     = 8,
    parameter int  N_RST_REGS = 4,
    parameter int  N_EN_REGS  = 4,
    parameter int  RST_BASE   = 'h10,
    parameter int  EN_BASE    = 'h30,
    parameter int  LAST_OFF   = 'h90,
    localparam int WORD_W     = pgc_pkg::WORD_W,
    localparam int RST_LINES  = N_RST_REGS * WORD_W,
    localparam int EN_LINES   = N_EN_REGS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [WORD_W-1:0]    wdata,
    output logic [WORD_W-1:0]    rdata,
    output logic [RST_LINES-1:0] rst_evt,
    output logic [RST_LINES-1:0] rst_lvl,
    output logic [EN_LINES-1:0]  en_evt,
    output logic [EN_LINES-1:0]  en_lvl
);
    import pgc_pkg::*;

    localparam int IDX_W   = ADDR_W - 2;
    localparam int N_WORDS = LAST_OFF / 4 + 1;
    localparam int RGI_W   = (N_RST_REGS > 1) ? $clog2(N_RST_REGS) : 1;
    localparam int EGI_W   = (N_EN_REGS > 1) ? $clog2(N_EN_REGS) : 1;
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_OFF);
    localparam logic [ADDR_W-1:0] RST_LO = ADDR_W'(RST_BASE);
    localparam logic [ADDR_W-1:0] RST_HI = ADDR_W'(RST_BASE + 4 * N_RST_REGS);
    localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
    localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_BASE + 4 * N_EN_REGS);

    logic              in_range, wr_ok, rst_hit, en_hit;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] rst_off, en_off;
    logic [WORD_W-1:0] old_word, rd_word, rdata_cap;
    bus_state_e        state_q, state_d;

    assign idx      = addr[ADDR_W-1:2];
    assign in_range = (addr <= LAST_A);
    assign wr_ok    = wr_en && in_range;
    assign rst_hit  = wr_ok && (addr >= RST_LO) && (addr < RST_HI);
    assign en_hit   = wr_ok && (addr >= EN_LO) && (addr < EN_HI);
    assign rst_off  = addr - RST_LO;
    assign en_off   = addr - EN_LO;

    pgc_bank #(.IDX_W(IDX_W), .WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .widx(idx), .wdata(wdata),
        .ridx(idx), .old_word(old_word), .rd_word(rd_word)
    );

    pgc_edge_group #(.N_REGS(N_RST_REGS), .WORD_W(WORD_W), .RISE(1'b0), .LVL_INIT(1'b1)) u_rst_grp (
        .clk(clk), .rst_n(rst_n), .hit(rst_hit), .gidx(rst_off[RGI_W+1:2]),
        .old_word(old_word), .new_word(wdata), .evt(rst_evt), .lvl(rst_lvl)
    );

    pgc_edge_group #(.N_REGS(N_EN_REGS), .WORD_W(WORD_W), .RISE(1'b1), .LVL_INIT(1'b0)) u_en_grp (
        .clk(clk), .rst_n(rst_n), .hit(en_hit), .gidx(en_off[EGI_W+1:2]),
        .old_word(old_word), .new_word(wdata), .evt(en_evt), .lvl(en_lvl)
    );

    // Next-state logic of the read response FSM
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_cap <= '0;
        else if (rd_en) rdata_cap <= in_range ? rd_word : '0;
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            BUS_IDLE: rdata = '0;
            BUS_RESP: rdata = rdata_cap;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
    parameter int ADDR_W   = 8,
    parameter int LINES    = 128,
    parameter int LAST_OFF = 'h90
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic [LINES-1:0]  rst_evt,
    input logic [LINES-1:0]  rst_lvl,
    input logic [LINES-1:0]  en_evt,
    input logic [LINES-1:0]  en_lvl
);
    a_r3_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr > ADDR_W'(LAST_OFF))) |=> (rdata == 32'd0));
    a_r4_oob_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr > ADDR_W'(LAST_OFF))) |=> (rst_evt == '0 && en_evt == '0));
    a_r5_rst_lvl_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_lvl & ~$past(rst_lvl)) == '0));
    a_r5_rst_evt_clears_lvl: assert property (@(posedge clk) disable iff (!rst_n)
        ((rst_evt & rst_lvl) == '0));
    a_r6_en_lvl_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        ((~en_lvl & $past(en_lvl)) == '0));
    a_r6_en_evt_sets_lvl: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_evt & ~en_lvl) == '0));
    a_r9_evt_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rst_evt) || (|en_evt)) |-> $past(wr_en));
    a_r9_groups_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((|rst_evt) && (|en_evt)));
    a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == 32'd0));
endmodule

bind periph_gate_ctrl pgc_checker #(.ADDR_W(ADDR_W), .LINES(RST_LINES), .LAST_OFF(LAST_OFF)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rdata(rdata),
    .rst_evt(rst_evt), .rst_lvl(rst_lvl), .en_evt(en_evt), .en_lvl(en_lvl)
);

// File: tb/periph_gate_ctrl_tb.sv
module periph_gate_ctrl_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [127:0] rst_evt, rst_lvl, en_evt, en_lvl;

    int checks = 0, failures = 0;
    logic [31:0]  m_regs [37];
    logic [127:0] m_rlvl, m_elvl;
    int unsigned  seed = 32'd12345;

    always #10 clk = ~clk;

    periph_gate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_evt(rst_evt), .rst_lvl(rst_lvl),
        .en_evt(en_evt), .en_lvl(en_lvl)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a > 8'h90) return 32'd0;
        return m_regs[a[7:2]];
    endfunction

    // R2 R3: read returns the expected word one cycle later
    task automatic do_read(input logic [7:0] a, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, {96'd0, rdata}, {96'd0, exp_read(a)});
    endtask

    // R4-R9: write, then compare strobes and levels with the model
    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        logic [127:0] er, ee;
        logic [31:0]  old;
        string        req;
        er = '0; ee = '0; req = "R8";
        if (a > 8'h90) begin
            req = "R4";
        end else begin
            old = m_regs[a[7:2]];
            if (a >= 8'h10 && a < 8'h20) begin
                req = "R5/R7";
                er[(a[3:2])*32 +: 32] = old & ~d;
            end else if (a >= 8'h30 && a < 8'h40) begin
                req = "R6/R7";
                ee[(a[3:2])*32 +: 32] = ~old & d;
            end
            m_regs[a[7:2]] = d;
        end
        m_rlvl = m_rlvl & ~er;
        m_elvl = m_elvl | ee;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk({req, " rst_evt"}, rst_evt, er);
        chk({req, " en_evt"}, en_evt, ee);
        chk({req, " rst_lvl"}, rst_lvl, m_rlvl);
        chk({req, " en_lvl"}, en_lvl, m_elvl);
        @(negedge clk);
        chk("R9 strobe width", {rst_evt | en_evt}, 128'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0]  a;
        logic [31:0] d;
        int          bucket;
        for (int i = 0; i < 37; i++) m_regs[i] = '0;
        m_rlvl = '1; m_elvl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rst_lvl", rst_lvl, '1);
        chk("R1 en_lvl", en_lvl, '0);
        chk("R1 events", {rst_evt | en_evt}, '0);
        chk("R2 idle rdata", {96'd0, rdata}, '0);
        for (int i = 0; i <= 'h90; i += 4) do_read(8'(i), "R1 reg zero");

        // Directed corners
        do_write(8'h14, 32'hFFFF_FFFF);          // R7 reset bits rising: stored, no event
        do_read(8'h14, "R7 stored");
        do_write(8'h14, 32'h0000_0001);          // R5 lines 32+1..32+31 released
        do_write(8'h3C, 32'h8000_0000);          // R6 line 127 enabled
        do_write(8'h3C, 32'h0000_0000);          // R7 enable falling: no event
        do_read(8'h3F, "R2 low bits ignored");
        do_write(8'h90, 32'hA5A5_5A5A);          // R8 last in-range word
        do_read(8'h90, "R8 stored");
        do_write(8'h94, 32'hDEAD_BEEF);          // R4 discarded
        do_read(8'h94, "R3 oob read");
        do_read(8'h91, "R3 oob unaligned");
        do_read(8'h10, "R4 no alias");

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            bucket = int'($urandom(seed) % 4); seed = seed + 32'd7;
            d = $urandom();
            case (bucket)
                0: a = 8'h10 + 8'(($urandom() % 4) * 4);
                1: a = 8'h30 + 8'(($urandom() % 4) * 4);
                2: a = 8'(($urandom() % 37) * 4);
                default: a = 8'h91 + 8'($urandom() % 8'h6F);
            endcase
            if ($urandom() % 3 == 0) do_read(a, "R2/R3 random read");
            else do_write(a, d);
        end
        for (int i = 0; i <= 'h90; i += 4) do_read(8'(i), "R8 final bank");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule